// File: doc/BRIEF.md
# Corrected-Error Threshold Interrupt Bank

This block is a single error-reporting bank. It counts corrected errors and asks for an interrupt once enough of them have accumulated. Software reaches two 64-bit registers through a plain register port: a control word and a status word. A one-cycle pulse on `err_pulse` reports each corrected error. The status word records that an error has been seen and keeps a saturating count of the errors. The control word holds an enable for threshold interrupts and a threshold value.

Software can discover what the bank supports by reading back what it wrote. When the bank lacks threshold interrupts, the enable bit always reads zero. Threshold bits above the implemented width also read zero. Writing all ones and reading the result therefore gives the largest usable threshold. The implemented width is a parameter from 1 to 15 bits.

In normal use, software programs the threshold and sets the enable. When `irq` is raised, the handler services the bank and clears the status word, after which the bank logs new errors again.

Top module: `ce_thresh_bank`

## Requirements
- R1: Control bit 30 is the interrupt enable. A written 1 reads back as 1 when `SUPPORT_EN`=1. It always reads back as 0 when `SUPPORT_EN`=0.
- R2: The control threshold field is bits 15:0. Only the low `THR_W` bits are stored. Bits 15:`THR_W`, 29:16 and 63:31 read back as zero.
- R3: Each accepted error pulse sets status bit 63 (the valid flag) and adds one to the count in status bits 52:38. The new value is readable in the cycle after the pulse.
- R4: The count saturates at 0x7FFF and does not wrap.
- R5: With the enable set and a stored threshold of 1, every accepted error raises `irq` in the cycle after the pulse.
- R6: With the enable set and a stored threshold above 1, `irq` is high for exactly one cycle. This happens in the cycle after the pulse that makes the count equal the threshold, and only once until the count is rewritten.
- R7: No interrupt is raised while the enable is 0, while the stored threshold is 0, or when `SUPPORT_EN`=0.
- R8: A status write loads the valid flag from data bit 63 and the count from data bits 52:38. Writing zero clears both, and the next error then gives a count of 1.
- R9: If a status write and an error pulse fall in the same cycle, the write wins. The pulse is dropped and raises no interrupt.
- R10: After reset, both registers read zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_sel | input | 1 | Register select: 0 control, 1 status |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 64 | Write data |
| rd_data | output | 64 | Read data of the selected register (combinational) |
| err_pulse | input | 1 | One-cycle corrected-error event |
| irq | output | 1 | One-cycle interrupt request |

## Verification
A table of threshold scenarios drives the counting and interrupt path:
- A threshold of 1 tells the every-error rule apart from the equality rule.
- A larger threshold, with more pulses than needed, shows that the interrupt fires once and not again.
- The same threshold with the enable off, and a zero threshold, separate the two gating conditions.
- Written values with bits above the implemented width show that masking happens before comparison.

Directed cases cover read-back probing on a supported bank and an unsupported bank, preloading the count near its limit to reach saturation, clearing and relogging, and a write colliding with an error pulse.

// File: rtl/ce_thresh_pkg.sv
package ce_thresh_pkg;
  localparam int REG_W     = 64;
  localparam int EN_BIT    = 30;
  localparam int THR_FLD_W = 16;
  localparam int CNT_LO    = 38;
  localparam int CNT_W     = 15;
  localparam int VALID_BIT = 63;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  typedef enum logic {
    SEL_CTL  = 1'b0,
    SEL_STAT = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/ce_rst_sync.sv
module ce_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/ce_ctl_reg.sv
module ce_ctl_reg #(
  parameter int THR_W      = 12,
  parameter bit SUPPORT_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_en_bit,
  input  logic [THR_W-1:0] wr_thr,
  output logic             en_o,
  output logic [THR_W-1:0] thr_o
);
  logic [THR_W-1:0] thr_q, thr_d;

  always_comb begin
    thr_d = thr_q;
    if (wr_en) thr_d = wr_thr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) thr_q <= '0;
    else        thr_q <= thr_d;
  end

  generate
    if (SUPPORT_EN) begin : g_en
      logic en_q, en_d;
      always_comb begin
        en_d = en_q;
        if (wr_en) en_d = wr_en_bit;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en_d;
      end
      assign en_o = en_q;
    end else begin : g_no_en
      assign en_o = 1'b0;
    end
  endgenerate

  assign thr_o = thr_q;
endmodule

// File: rtl/ce_stat_cnt.sv
module ce_stat_cnt
  import ce_thresh_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_valid,
  input  logic [CNT_W-1:0] wr_cnt,
  input  logic             err_pulse,
  output logic             valid_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             accept_o
);
  logic             valid_q, valid_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             accept;

  assign accept = err_pulse && !wr_en;

  always_comb begin
    valid_d = valid_q;
    cnt_d   = cnt_q;
    if (wr_en) begin
      valid_d = wr_valid;
      cnt_d   = wr_cnt;
    end else if (accept) begin
      valid_d = 1'b1;
      if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      valid_q <= valid_d;
      cnt_q   <= cnt_d;
    end
  end

  assign valid_o  = valid_q;
  assign cnt_o    = cnt_q;
  assign accept_o = accept;
endmodule

// File: rtl/ce_irq_gen.sv
module ce_irq_gen
  import ce_thresh_pkg::*;
#(
  parameter int THR_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [CNT_W-1:0] cnt,
  input  logic             en,
  input  logic [THR_W-1:0] thr,
  output logic             irq_o
);
  logic [CNT_W-1:0] thr_ext;
  logic [CNT_W-1:0] cnt_inc;
  logic             hit, irq_d, irq_q;

  assign thr_ext = CNT_W'(thr);
  assign cnt_inc = cnt + 1'b1;

  always_comb begin
    hit = 1'b0;
    if (thr_ext == CNT_W'(1))
      hit = 1'b1;
    else if (thr_ext != '0 && cnt != CNT_MAX && cnt_inc == thr_ext)
      hit = 1'b1;
    irq_d = accept && en && hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/ce_thresh_bank.sv
module ce_thresh_bank
  import ce_thresh_pkg::*;
#(
  parameter int THR_W      = 12,
  parameter bit SUPPORT_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_sel,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             err_pulse,
  output logic             irq
);
  logic             rst_sync_n;
  logic             ctl_wr, stat_wr;
  logic             en_w;
  logic [THR_W-1:0] thr_w;
  logic             valid_w, accept_w;
  logic [CNT_W-1:0] cnt_w;
  logic [REG_W-1:0] ctl_word, stat_word;

  assign ctl_wr  = wr_en && (reg_sel == SEL_CTL);
  assign stat_wr = wr_en && (reg_sel == SEL_STAT);

  ce_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  ce_ctl_reg #(.THR_W(THR_W), .SUPPORT_EN(SUPPORT_EN)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (ctl_wr),
    .wr_en_bit (wr_data[EN_BIT]),
    .wr_thr    (wr_data[THR_W-1:0]),
    .en_o      (en_w),
    .thr_o     (thr_w)
  );

  ce_stat_cnt u_stat (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (stat_wr),
    .wr_valid  (wr_data[VALID_BIT]),
    .wr_cnt    (wr_data[CNT_LO +: CNT_W]),
    .err_pulse (err_pulse),
    .valid_o   (valid_w),
    .cnt_o     (cnt_w),
    .accept_o  (accept_w)
  );

  ce_irq_gen #(.THR_W(THR_W)) u_irq (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .accept (accept_w),
    .cnt    (cnt_w),
    .en     (en_w),
    .thr    (thr_w),
    .irq_o  (irq)
  );

  always_comb begin
    ctl_word              = '0;
    ctl_word[EN_BIT]      = en_w;
    ctl_word[THR_W-1:0]   = thr_w;
    stat_word             = '0;
    stat_word[VALID_BIT]  = valid_w;
    stat_word[CNT_LO +: CNT_W] = cnt_w;
    rd_data = (reg_sel == SEL_STAT) ? stat_word : ctl_word;
  end
endmodule

// File: rtl/ce_thresh_bank_chk.sv
module ce_thresh_bank_chk
  import ce_thresh_pkg::*;
#(
  parameter int THR_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_sel,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic [REG_W-1:0] rd_data,
  input logic             err_pulse,
  input logic             irq,
  input logic [CNT_W-1:0] cnt,
  input logic             valid,
  input logic             en,
  input logic [THR_W-1:0] thr
);
  logic stat_wr;
  assign stat_wr = wr_en && (reg_sel == SEL_STAT);

  AST_CTL_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == SEL_CTL) |-> (rd_data[15:THR_W] == '0 && rd_data[29:16] == '0 && rd_data[63:31] == '0)); // R2

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (err_pulse && !stat_wr && cnt != CNT_MAX) |=> (valid && cnt == CNT_W'($past(cnt) + 1'b1))); // R3

  AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX && !stat_wr) |=> (cnt == CNT_MAX)); // R4

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && thr > THR_W'(1) && !wr_en) |=> !irq); // R6

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(en) && $past(thr) != '0)); // R7

  AST_CLEAR_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && wr_data == '0) |=> (!valid && cnt == '0)); // R8

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && err_pulse) |=> !irq); // R9
endmodule

bind ce_thresh_bank ce_thresh_bank_chk #(.THR_W(THR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .reg_sel   (reg_sel),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .rd_data   (rd_data),
  .err_pulse (err_pulse),
  .irq       (irq),
  .cnt       (cnt_w),
  .valid     (valid_w),
  .en        (en_w),
  .thr       (thr_w)
);

// File: tb/sim_ce_thresh_bank.sv
`timescale 1ns/1ps
module sim_ce_thresh_bank;
  logic        clk;
  logic        rst_n;
  logic        reg_sel;
  logic        wr_en;
  logic [63:0] wr_data;
  logic [63:0] rd_data, rd_data1;
  logic        err_pulse;
  logic        irq, irq1;

  int checks = 0;
  int fails  = 0;
  int irq1_seen = 0;

  ce_thresh_bank #(.THR_W(12), .SUPPORT_EN(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .err_pulse(err_pulse), .irq(irq));

  ce_thresh_bank #(.THR_W(3), .SUPPORT_EN(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data1), .err_pulse(err_pulse), .irq(irq1));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(negedge clk) if (irq1) irq1_seen++;

  typedef struct packed {
    logic [15:0] thr;
    logic        en;
    logic [7:0]  npulse;
    logic [7:0]  nirq;
    logic [14:0] cnt;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t TBL [NVEC] = '{
    '{16'h0001, 1'b1, 8'd3, 8'd3, 15'd3},   // R5 every error
    '{16'h0004, 1'b1, 8'd6, 8'd1, 15'd6},   // R6 once at crossing
    '{16'h0004, 1'b0, 8'd6, 8'd0, 15'd6},   // R7 enable off
    '{16'h0000, 1'b1, 8'd5, 8'd0, 15'd5},   // R7 zero threshold
    '{16'h0002, 1'b1, 8'd2, 8'd1, 15'd2},   // R6 fires on last pulse
    '{16'h1005, 1'b1, 8'd6, 8'd1, 15'd6},   // R2 masked to 5
    '{16'hF001, 1'b1, 8'd2, 8'd2, 15'd2}    // R2 masked to 1, R5
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic sel, input logic [63:0] d);
    reg_sel = sel; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd_reg(input logic sel, output logic [63:0] d);
    reg_sel = sel;
    #1 d = rd_data;
  endtask

  task automatic pulse(output logic seen);
    err_pulse = 1'b1;
    @(negedge clk);
    err_pulse = 1'b0;
    seen = irq;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL all watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] d;
    logic        s;
    int          n;
    rst_n = 1'b0; reg_sel = 1'b0; wr_en = 1'b0; wr_data = '0; err_pulse = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    rd_reg(1'b0, d); check(d == 64'h0, "R10 ctl", d, 64'h0);
    rd_reg(1'b1, d); check(d == 64'h0, "R10 stat", d, 64'h0);
    check(irq == 1'b0, "R10 irq", {63'h0, irq}, 64'h0);

    // R1 R2 probing by writing all ones
    wr_reg(1'b0, '1);
    rd_reg(1'b0, d);
    check(d == 64'h0000_0000_4000_0FFF, "R1 R2 probe supported", d, 64'h4000_0FFF);
    check(rd_data1 == 64'h7, "R1 R2 probe unsupported", rd_data1, 64'h7);

    // table walk: R5 R6 R7 R2
    foreach (TBL[i]) begin
      wr_reg(1'b0, (64'(TBL[i].en) << 30) | 64'(TBL[i].thr));
      wr_reg(1'b1, 64'h0);
      n = 0;
      for (int k = 0; k < int'(TBL[i].npulse); k++) begin
        pulse(s);
        if (s) n++;
        @(negedge clk);
        if (irq) n++;
      end
      check(n == int'(TBL[i].nirq), "R5 R6 R7 irq count", 64'(n), 64'(TBL[i].nirq));
      rd_reg(1'b1, d);
      check(d[52:38] == TBL[i].cnt && d[63] == 1'b1, "R3 count", d, 64'(TBL[i].cnt));
    end

    // R4 saturation
    wr_reg(1'b0, (64'd1 << 30) | 64'd5);
    wr_reg(1'b1, (64'd1 << 63) | (64'h7FFE << 38));
    n = 0;
    for (int k = 0; k < 3; k++) begin
      pulse(s);
      if (s) n++;
    end
    check(n == 0, "R4 no irq near limit", 64'(n), 64'h0);
    rd_reg(1'b1, d);
    check(d == ((64'd1 << 63) | (64'h7FFF << 38)), "R4 saturate", d, (64'd1 << 63) | (64'h7FFF << 38));

    // R8 clear and relog
    wr_reg(1'b1, 64'h0);
    rd_reg(1'b1, d); check(d == 64'h0, "R8 cleared", d, 64'h0);
    pulse(s);
    rd_reg(1'b1, d);
    check(d == ((64'd1 << 63) | (64'd1 << 38)), "R8 R3 relog", d, (64'd1 << 63) | (64'd1 << 38));

    // R9 write collides with pulse, threshold 1
    wr_reg(1'b0, (64'd1 << 30) | 64'd1);
    reg_sel = 1'b1; wr_data = 64'h0; wr_en = 1'b1; err_pulse = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; err_pulse = 1'b0;
    check(irq == 1'b0, "R9 no irq", {63'h0, irq}, 64'h0);
    rd_reg(1'b1, d); check(d == 64'h0, "R9 pulse dropped", d, 64'h0);

    // R7 unsupported bank never interrupts
    check(irq1_seen == 0, "R7 unsupported irq", 64'(irq1_seen), 64'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule